// File: doc/BRIEF.md
# Busy-State Status Word Generator

This block forms the byte a host sees when it reads a flash array that is busy with an embedded program or erase, or that has erase parked in suspend. A separate controller decides the operation state and supplies it on `op_mode`. The array contents arrive on `array_data`. Bit 7 of the byte being programmed arrives on `prog_poll_bit`. A flag says whether the read address falls in a sector marked for erase. On each read strobe the block registers one byte. That byte is either the array data or a status word. The status word carries a polling bit, two bits that flip from one read to the next, a sticky failure flag and an erase-window flag.

The two flipping bits advance on completed reads, not on clock cycles. A host can therefore tell "busy" from "done" by reading twice and comparing. Both flipping bits return to 0 whenever the controller reports plain array-read mode. The failure flag is set by a pulse from the controller and stays set until a reset command pulse arrives.

Top module: `busy_status_word`

## Requirements
- R1: In op_mode 1 (program) and op_mode 5 (program within suspend), bit 7 of the status word is the inverse of `prog_poll_bit`.
- R2: In op_mode 2 (erase window) and op_mode 3 (erase running), bit 7 of the status word is 0.
- R3: Bit 6 starts at 0 after any cycle in array-read mode. It inverts on every read taken in op_mode 1, 2, 3 or 5. In op_mode 4 it holds its value.
- R4: Bit 5 reads 1 in every status word taken after a `limit_hit` pulse. It returns to 0 for reads taken after a `reset_cmd` pulse. Array-read mode in between does not clear it. When both pulses arrive in the same cycle, the clear wins.
- R5: Bit 3 of the status word is 0 in op_mode 2 and 1 in op_mode 3.
- R6: A read in op_mode 4 with `sel_sector` high gives bit 7 = 1, bit 6 held and bit 2 toggling.
- R7: A read returns `array_data` unchanged in op_mode 0. It does the same in op_mode 4 when `sel_sector` is low, and then leaves both flipping bits unchanged.
- R8: Bit 2 inverts only on reads with `sel_sector` high in op_mode 2, 3, 4 or 5, and holds otherwise. Status bits 4, 1 and 0 always read 0.
- R9: `rd_data` is 0 after reset. It changes only in the cycle after a cycle with `rd_stb` high, and holds between strobes.
- R10: The op_mode codes are 0 array read, 1 program, 2 erase window, 3 erase running, 4 erase suspended and 5 program within suspend. Codes 6 and 7 behave as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_mode | input | 3 | Operation state from the controller |
| prog_poll_bit | input | 1 | Bit 7 of the byte being programmed |
| sel_sector | input | 1 | Read address lies in a sector marked for erase |
| rd_stb | input | 1 | One-cycle pulse per completed host read |
| array_data | input | 8 | Array contents at the read address |
| limit_hit | input | 1 | Pulse: operation exceeded its pulse-count limit |
| reset_cmd | input | 1 | Pulse: reset command written |
| rd_data | output | 8 | Byte returned to the host |

## Verification
The properties assume that `op_mode`, `sel_sector` and `prog_poll_bit` are steady in the cycle a strobe is taken. They also assume `rd_stb` is a single-cycle pulse per read. The flip check further assumes that consecutive reads in flipping modes are not separated by a cycle in array-read mode, unless that gap is tracked. The bench drives every input at the falling edge and raises the strobe for exactly one cycle. It returns to mode 0 only through an explicit clear step, so the toggle history the properties rely on is always well defined.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

    localparam int DATA_W   = 8;
    localparam int MODE_W   = 3;
    localparam int POLL_BIT = 7;
    localparam int FLIP_BIT = 6;
    localparam int FAIL_BIT = 5;
    localparam int WIN_BIT  = 3;
    localparam int ALT_BIT  = 2;
    localparam int NUM_FLIP = 2;
    localparam int FLIP_MAIN = 0;
    localparam int FLIP_ALT  = 1;

    typedef enum logic [MODE_W-1:0] {
        MD_ARRAY     = 3'd0,
        MD_PROG      = 3'd1,
        MD_ER_WIN    = 3'd2,
        MD_ER_RUN    = 3'd3,
        MD_SUSP      = 3'd4,
        MD_SUSP_PROG = 3'd5,
        MD_RSV6      = 3'd6,
        MD_RSV7      = 3'd7
    } op_mode_e;

    typedef struct packed {
        logic status;
        logic poll_inv;
        logic poll_one;
        logic main_adv;
        logic alt_adv;
        logic erase_run;
        logic sect_array;
    } mode_attr_t;

    function automatic mode_attr_t decode_mode(input op_mode_e m);
        mode_attr_t a;
        a = '0;
        case (m)
            MD_PROG: begin
                a.status   = 1'b1;
                a.poll_inv = 1'b1;
                a.main_adv = 1'b1;
            end
            MD_ER_WIN: begin
                a.status   = 1'b1;
                a.main_adv = 1'b1;
                a.alt_adv  = 1'b1;
            end
            MD_ER_RUN: begin
                a.status    = 1'b1;
                a.main_adv  = 1'b1;
                a.alt_adv   = 1'b1;
                a.erase_run = 1'b1;
            end
            MD_SUSP: begin
                a.status     = 1'b1;
                a.poll_one   = 1'b1;
                a.alt_adv    = 1'b1;
                a.sect_array = 1'b1;
            end
            MD_SUSP_PROG: begin
                a.status   = 1'b1;
                a.poll_inv = 1'b1;
                a.main_adv = 1'b1;
                a.alt_adv  = 1'b1;
            end
            default: a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/bsw_flip.sv
module bsw_flip (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= 1'b0;
        end else if (adv) begin
            q <= ~q;
        end
    end
endmodule

// File: rtl/bsw_fail_latch.sv
module bsw_fail_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            q <= 1'b0;
        end else if (set_i) begin
            q <= 1'b1;
        end
    end
endmodule

// File: rtl/bsw_word_build.sv
module bsw_word_build
    import bsw_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  mode_attr_t       attr,
    input  logic             poll_src,
    input  logic             sel_sector,
    input  logic             flip_main,
    input  logic             flip_alt,
    input  logic             fail,
    input  logic [W-1:0]     array_data,
    output logic [W-1:0]     word
);
    logic [W-1:0] stat;
    logic         show_array;

    always_comb begin
        stat = '0;
        stat[POLL_BIT] = attr.poll_inv ? ~poll_src : attr.poll_one;
        stat[FLIP_BIT] = flip_main;
        stat[FAIL_BIT] = fail;
        stat[WIN_BIT]  = attr.erase_run;
        stat[ALT_BIT]  = flip_alt;
    end

    assign show_array = !attr.status || (attr.sect_array && !sel_sector);
    assign word       = show_array ? array_data : stat;
endmodule

// File: rtl/busy_status_word.sv
module busy_status_word
    import bsw_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [MODE_W-1:0]    op_mode,
    input  logic                 prog_poll_bit,
    input  logic                 sel_sector,
    input  logic                 rd_stb,
    input  logic [W-1:0]         array_data,
    input  logic                 limit_hit,
    input  logic                 reset_cmd,
    output logic [W-1:0]         rd_data
);
    mode_attr_t          attr;
    logic [NUM_FLIP-1:0] flip_adv;
    logic [NUM_FLIP-1:0] flip_q;
    logic                fail_q;
    logic [W-1:0]        word;

    assign attr = decode_mode(op_mode_e'(op_mode));

    assign flip_adv[FLIP_MAIN] = rd_stb && attr.main_adv;
    assign flip_adv[FLIP_ALT]  = rd_stb && attr.alt_adv && sel_sector;

    for (genvar i = 0; i < NUM_FLIP; i++) begin : g_flip
        bsw_flip u_flip (
            .clk (clk),
            .rst (rst),
            .clr (!attr.status),
            .adv (flip_adv[i]),
            .q   (flip_q[i])
        );
    end

    bsw_fail_latch u_fail (
        .clk   (clk),
        .rst   (rst),
        .set_i (limit_hit),
        .clr_i (reset_cmd),
        .q     (fail_q)
    );

    bsw_word_build #(.W(W)) u_build (
        .attr       (attr),
        .poll_src   (prog_poll_bit),
        .sel_sector (sel_sector),
        .flip_main  (flip_q[FLIP_MAIN]),
        .flip_alt   (flip_q[FLIP_ALT]),
        .fail       (fail_q),
        .array_data (array_data),
        .word       (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_stb) begin
            rd_data <= word;
        end
    end
endmodule

// File: rtl/busy_status_word_chk.sv
module busy_status_word_chk
    import bsw_pkg::*;
#(
    parameter int W = DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic [MODE_W-1:0] op_mode,
    input logic              prog_poll_bit,
    input logic              sel_sector,
    input logic              rd_stb,
    input logic [W-1:0]      array_data,
    input logic              limit_hit,
    input logic              reset_cmd,
    input logic [W-1:0]      rd_data
);
    logic flip_mode;
    logic seen;

    assign flip_mode = (op_mode == 3'd1) || (op_mode == 3'd2) ||
                       (op_mode == 3'd3) || (op_mode == 3'd5);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= 1'b0;
        end else if (rd_stb) begin
            seen <= flip_mode;
        end else if (op_mode == 3'd0 || op_mode > 3'd5) begin
            seen <= 1'b0;
        end
    end

    p_poll_inv_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && (op_mode == 3'd1 || op_mode == 3'd5)) |=> rd_data[7] == ~$past(prog_poll_bit));

    p_erase_poll_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && (op_mode == 3'd2 || op_mode == 3'd3)) |=> !rd_data[7]);

    p_flip_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && flip_mode && seen) |=> rd_data[6] != $past(rd_data[6]));

    p_fail_set_r4: assert property (@(posedge clk) disable iff (rst)
        (limit_hit && !reset_cmd) |=> ##0 (rd_stb && op_mode >= 3'd1 && op_mode <= 3'd3) |=> rd_data[5]);

    p_fail_clr_r4: assert property (@(posedge clk) disable iff (rst)
        (reset_cmd && !limit_hit) |=> ##0 (rd_stb && op_mode >= 3'd1 && op_mode <= 3'd3 && !limit_hit) |=> !rd_data[5]);

    p_window_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && op_mode == 3'd2) |=> !rd_data[3]);

    p_running_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && op_mode == 3'd3) |=> rd_data[3]);

    p_susp_sector_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && op_mode == 3'd4 && sel_sector) |=> rd_data[7]);

    p_array_pass_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && (op_mode == 3'd0 || (op_mode == 3'd4 && !sel_sector))) |=> rd_data == $past(array_data));

    p_zero_bits_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && op_mode >= 3'd1 && op_mode <= 3'd3) |=> (rd_data[4] == 1'b0 && rd_data[1:0] == 2'b00));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(rd_data));

    p_reserved_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && op_mode > 3'd5) |=> rd_data == $past(array_data));
endmodule

bind busy_status_word busy_status_word_chk #(.W(W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .op_mode       (op_mode),
    .prog_poll_bit (prog_poll_bit),
    .sel_sector    (sel_sector),
    .rd_stb        (rd_stb),
    .array_data    (array_data),
    .limit_hit     (limit_hit),
    .reset_cmd     (reset_cmd),
    .rd_data       (rd_data)
);

// File: tb/busy_status_word_test.sv
module busy_status_word_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op_mode = 3'd0;
    logic       prog_poll_bit = 1'b0;
    logic       sel_sector = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] array_data = 8'h00;
    logic       limit_hit = 1'b0;
    logic       reset_cmd = 1'b0;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    busy_status_word uut (
        .clk           (clk),
        .rst           (rst),
        .op_mode       (op_mode),
        .prog_poll_bit (prog_poll_bit),
        .sel_sector    (sel_sector),
        .rd_stb        (rd_stb),
        .array_data    (array_data),
        .limit_hit     (limit_hit),
        .reset_cmd     (reset_cmd),
        .rd_data       (rd_data)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_read(input logic [2:0] m, input logic sel, input logic [7:0] arr,
                           input logic pb, output logic [7:0] got);
        @(negedge clk);
        op_mode = m; sel_sector = sel; array_data = arr; prog_poll_bit = pb;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        got = rd_data;
    endtask

    task automatic clear_flips();
        @(negedge clk);
        op_mode = 3'd0; rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R9 reset value", rd_data, 8'h00);
    endtask

    task automatic t_array();
        logic [7:0] g;
        do_read(3'd0, 1'b0, 8'hA5, 1'b0, g); check("R7 array read", g, 8'hA5);
        do_read(3'd0, 1'b1, 8'h3C, 1'b1, g); check("R7 array read 2", g, 8'h3C);
        do_read(3'd6, 1'b0, 8'h96, 1'b0, g); check("R10 code 6", g, 8'h96);
        do_read(3'd7, 1'b1, 8'h69, 1'b0, g); check("R10 code 7", g, 8'h69);
    endtask

    task automatic t_program();
        logic [7:0] g;
        clear_flips();
        do_read(3'd1, 1'b0, 8'hFF, 1'b1, g); check("R1 R3 prog read 1", g, 8'h00);
        do_read(3'd1, 1'b0, 8'hFF, 1'b1, g); check("R3 prog read 2", g, 8'h40);
        do_read(3'd1, 1'b0, 8'hFF, 1'b0, g); check("R1 prog read 3", g, 8'h80);
    endtask

    task automatic t_erase();
        logic [7:0] g;
        clear_flips();
        do_read(3'd2, 1'b1, 8'hFF, 1'b0, g); check("R2 R5 window read 1", g, 8'h00);
        do_read(3'd2, 1'b1, 8'hFF, 1'b0, g); check("R3 R8 window read 2", g, 8'h44);
        do_read(3'd2, 1'b1, 8'hFF, 1'b0, g); check("R8 window read 3", g, 8'h00);
        do_read(3'd3, 1'b1, 8'hFF, 1'b0, g); check("R5 running read", g, 8'h4C);
        do_read(3'd3, 1'b0, 8'hFF, 1'b0, g); check("R8 outside sector 1", g, 8'h08);
        do_read(3'd3, 1'b0, 8'hFF, 1'b0, g); check("R8 outside sector 2", g, 8'h48);
    endtask

    task automatic t_suspend();
        logic [7:0] g;
        clear_flips();
        do_read(3'd4, 1'b1, 8'h11, 1'b0, g); check("R6 suspended sector 1", g, 8'h80);
        do_read(3'd4, 1'b1, 8'h11, 1'b0, g); check("R6 suspended sector 2", g, 8'h84);
        do_read(3'd4, 1'b1, 8'h11, 1'b0, g); check("R6 suspended sector 3", g, 8'h80);
        do_read(3'd4, 1'b0, 8'h5A, 1'b0, g); check("R7 other sector array", g, 8'h5A);
        do_read(3'd4, 1'b1, 8'h11, 1'b0, g); check("R7 flips untouched", g, 8'h84);
    endtask

    task automatic t_susp_prog();
        logic [7:0] g;
        clear_flips();
        do_read(3'd5, 1'b0, 8'h00, 1'b0, g); check("R1 suspend program 1", g, 8'h80);
        do_read(3'd5, 1'b0, 8'h00, 1'b0, g); check("R3 suspend program 2", g, 8'hC0);
    endtask

    task automatic t_fail();
        logic [7:0] g;
        clear_flips();
        @(negedge clk); op_mode = 3'd1; limit_hit = 1'b1;
        @(negedge clk); limit_hit = 1'b0;
        do_read(3'd1, 1'b0, 8'h00, 1'b1, g); check("R4 fail set 1", g, 8'h20);
        do_read(3'd1, 1'b0, 8'h00, 1'b1, g); check("R4 fail set 2", g, 8'h60);
        clear_flips();
        do_read(3'd1, 1'b0, 8'h00, 1'b1, g); check("R4 fail survives array mode", g, 8'h20);
        @(negedge clk); limit_hit = 1'b1; reset_cmd = 1'b1;
        @(negedge clk); limit_hit = 1'b0; reset_cmd = 1'b0;
        do_read(3'd1, 1'b0, 8'h00, 1'b1, g); check("R4 clear wins", g, 8'h40);
    endtask

    task automatic t_hold();
        logic [7:0] g;
        do_read(3'd0, 1'b0, 8'hC3, 1'b0, g);
        @(negedge clk); op_mode = 3'd3; array_data = 8'h00; sel_sector = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R9 hold without strobe", rd_data, 8'hC3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_array();
        t_program();
        t_erase();
        t_suspend();
        t_susp_prog();
        t_fail();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule